// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a watchdog that escalates in stages. A free-running timebase counter advances once for each cycle in which the tick enable is high. A 2-bit period field in the control register picks which counter bit acts as the watchdog tap. Each rising edge of that bit is one expiry. The watchdog position is held in the top two bits of a 32-bit status word:

- On the first expiry the watchdog becomes armed.
- On the next expiry the interrupt stage is entered and an interrupt can be raised.
- On a later expiry the configured reset kind is copied into the status word, and when that kind is non-zero a single-cycle reset request leaves the block.

Software services the watchdog by writing the status register so that its two stage bits return to zero. Distributing the reset is left to the logic outside.

Both registers are seen as 32-bit words with fixed field positions:

| Register | Bits | Meaning |
|---|---|---|
| Control | 31:30 | Period select |
| Control | 29:28 | Reset kind (00 none; 01, 10, 11 core, chip and system) |
| Control | 27 | Interrupt enable |
| Control | 26:23 | Kept as plain storage |
| Status | 31 | Armed |
| Status | 30 | Interrupt stage |
| Status | 29:28 | Recorded reset kind |
| Status | 27:26 | Kept as plain storage |

Top module: `wdog_escalator`

## Requirements
- R1: After reset the control readback, the status readback, `wd_irq`, `rst_req` and `rst_kind` are all zero, and the timebase counter is zero.
- R2: A control write keeps only bits 31:23 of `ctl_wdata`. Bits 22:0 of `ctl_rdata` always read zero. The new value appears on `ctl_rdata` in the cycle after the write edge.
- R3: A status write keeps only bits 31:26 of `sts_wdata`. Bits 25:0 of `sts_rdata` always read zero. A status write takes priority over an expiry at the same edge, and that expiry is lost.
- R4: The counter advances by one only in cycles with `tick_en` high. An expiry is a 0-to-1 change of counter bit TB_BASE_BIT + TB_STEP*P, where P is control bits 31:30. With the defaults the expiries are 2^17, 2^21, 2^25 or 2^29 ticks apart.
- R5: An expiry while status bits 31:30 are 00 or 01 sets status bit 31. From 01 this moves the watchdog to 11.
- R6: An expiry while status bits 31:30 are 10 sets status bit 30. `wd_irq` equals status bit 30 AND control bit 27.
- R7: An expiry while status bits 31:30 are 11 copies control bits 29:28 into status bits 29:28. When that value is non-zero, `rst_req` is high for exactly one cycle, starting at the same edge, and `rst_kind` carries the value. When the value is 00, no request is issued.
- R8: Once the final stage has been handled, further expiries change nothing and issue no request. This holds until a status write moves bits 31:30 away from 11.
- R9: Writing status bits 31:30 to 00 restarts the escalation. The next expiry arms the watchdog again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase advance enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data |
| ctl_rdata | output | 32 | Control register readback |
| sts_rdata | output | 32 | Status register readback |
| wd_irq | output | 1 | Watchdog interrupt, level |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_kind | output | 2 | Reset kind that goes with the request |

## Verification
The bench reaches the final stage with a non-zero kind, then lets the watchdog keep expiring there. A design without the once-only guard would pulse `rst_req` again on every later period. The bench also enters the 01 state from software and expires it. A design that decoded the stage as a counter would move to 10 instead of 11. A status write is placed on the exact tick of an expiry, so a design that let the expiry win would show the armed bit. The bench also changes the period select and runs the final stage with kind 00 and the interrupt disabled, which catches a wrong tap index, a request with no reset kind, and an interrupt that ignores its enable.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;

   // Stage code held in status bits 31:30
   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_PEND  = 2'b01,
      ST_ARMED = 2'b10,
      ST_FINAL = 2'b11
   } stage_e;

   localparam int CTL_KEEP = 9;   // control bits kept: 31:23
   localparam int STS_KEEP = 6;   // status bits kept: 31:26

   // Control word, upper nine bits
   typedef struct packed {
      logic [1:0] period;    // 31:30
      logic [1:0] rst_ctl;   // 29:28
      logic       wd_ie;     // 27
      logic [3:0] spare;     // 26:23
   } ctl_t;

   // Status word, upper six bits
   typedef struct packed {
      stage_e     stage;     // 31:30
      logic [1:0] rst_seen;  // 29:28
      logic [1:0] spare;     // 27:26
   } sts_t;

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
   parameter int BASE_BIT = 16,
   parameter int STEP     = 4,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en_i,
   input  logic [SEL_W-1:0] period_i,
   output logic             expire_o
);
   localparam int NUM_SEL = 1 << SEL_W;
   localparam int CNT_W   = BASE_BIT + STEP * (NUM_SEL - 1) + 1;

   if (BASE_BIT < 1) begin : g_bad_base
      $error("wdog_timebase: BASE_BIT must be at least 1");
   end
   if (STEP < 1) begin : g_bad_step
      $error("wdog_timebase: STEP must be at least 1");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_nx;
   logic [NUM_SEL-1:0] tap_rise;

   assign cnt_nx = cnt_q + CNT_W'(1);

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
      localparam int TAP = BASE_BIT + STEP * g;
      assign tap_rise[g] = ~cnt_q[TAP] & cnt_nx[TAP];
   end

   assign expire_o = tick_en_i & tap_rise[period_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (tick_en_i) cnt_q <= cnt_nx;
   end

   // R4: counter holds without a tick
   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en_i |=> $stable(cnt_q));
   // R4: an expiry always moves the counter
   assert_expiry_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> cnt_q != $past(cnt_q));

endmodule

// File: rtl/wdog_ctlreg.sv
module wdog_ctlreg
   import wdog_esc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output ctl_t              ctl_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int LOW_W = DATA_W - CTL_KEEP;

   if (DATA_W < CTL_KEEP + 1) begin : g_bad_width
      $error("wdog_ctlreg: DATA_W too small");
   end

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (we_i) ctl_q <= ctl_t'(wdata_i[DATA_W-1 -: CTL_KEEP]);
   end

   assign ctl_o   = ctl_q;
   assign rdata_o = {ctl_q, {LOW_W{1'b0}}};

   // R2: the stored value follows the upper bits of the write
   assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> rdata_o == {$past(wdata_i[DATA_W-1 -: CTL_KEEP]), {LOW_W{1'b0}}});

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
   import wdog_esc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire_i,
   input  logic       sw_we_i,
   input  sts_t       sw_data_i,
   input  ctl_t       ctl_i,
   output sts_t       sts_o,
   output logic       irq_o,
   output logic       rst_req_o,
   output logic [1:0] rst_kind_o
);
   sts_t       sts_q, sts_nx;
   logic       done_q, done_nx;
   logic       final_hit, fire;
   logic       req_q;
   logic [1:0] kind_q;

   always_comb begin
      sts_nx    = sts_q;
      final_hit = 1'b0;
      fire      = 1'b0;
      if (sw_we_i) begin
         sts_nx = sw_data_i;
      end else if (expire_i && !done_q) begin
         unique case (sts_q.stage)
            ST_IDLE:  sts_nx.stage = ST_ARMED;
            ST_PEND:  sts_nx.stage = ST_FINAL;
            ST_ARMED: sts_nx.stage = ST_FINAL;
            ST_FINAL: begin
               sts_nx.rst_seen = ctl_i.rst_ctl;
               final_hit       = 1'b1;
               fire            = (ctl_i.rst_ctl != 2'b00);
            end
            default: sts_nx = sts_q;
         endcase
      end
      done_nx = (sts_nx.stage == ST_FINAL) && (done_q || final_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q  <= '0;
         done_q <= 1'b0;
         req_q  <= 1'b0;
         kind_q <= 2'b00;
      end else begin
         sts_q  <= sts_nx;
         done_q <= done_nx;
         req_q  <= fire;
         kind_q <= fire ? ctl_i.rst_ctl : 2'b00;
      end
   end

   assign sts_o      = sts_q;
   assign irq_o      = sts_q.stage[0] & ctl_i.wd_ie;
   assign rst_req_o  = req_q;
   assign rst_kind_o = kind_q;

   // R3: a software write overrides anything else at the same edge
   assert_sw_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we_i |=> sts_q == $past(sw_data_i));
   // R5: an expiry with bit 31 clear sets it
   assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !sw_we_i && !sts_q.stage[1]) |=> sts_q.stage[1]);
   // R6: an expiry from the armed stage enters the interrupt stage
   assert_irq_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !sw_we_i && sts_q.stage == ST_ARMED) |=> sts_q.stage == ST_FINAL);
   // R7: the request lasts one cycle
   assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
   // R7: the request carries a non-zero kind that is recorded in status
   assert_kind_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (rst_kind_o != 2'b00) && (sts_q.rst_seen == rst_kind_o));
   // R8: after the final stage nothing moves until software intervenes
   assert_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !sw_we_i) |=> $stable(sts_q) && !rst_req_o);

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
   import wdog_esc_pkg::*;
#(
   parameter int TB_BASE_BIT = 16,
   parameter int TB_STEP     = 4,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              sts_we,
   input  logic [DATA_W-1:0] sts_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic [DATA_W-1:0] sts_rdata,
   output logic              wd_irq,
   output logic              rst_req,
   output logic [1:0]        rst_kind
);
   localparam int STS_LOW = DATA_W - STS_KEEP;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("wdog_escalator: field layout assumes a 32-bit word");
   end

   ctl_t ctl;
   sts_t sts;
   logic expire;

   wdog_ctlreg #(.DATA_W(DATA_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctl_we),
      .wdata_i (ctl_wdata),
      .ctl_o   (ctl),
      .rdata_o (ctl_rdata)
   );

   wdog_timebase #(.BASE_BIT(TB_BASE_BIT), .STEP(TB_STEP), .SEL_W(2)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en_i (tick_en),
      .period_i  (ctl.period),
      .expire_o  (expire)
   );

   wdog_stage u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire_i   (expire),
      .sw_we_i    (sts_we),
      .sw_data_i  (sts_t'(sts_wdata[DATA_W-1 -: STS_KEEP])),
      .ctl_i      (ctl),
      .sts_o      (sts),
      .irq_o      (wd_irq),
      .rst_req_o  (rst_req),
      .rst_kind_o (rst_kind)
   );

   assign sts_rdata = {sts, {STS_LOW{1'b0}}};

   // R6: the interrupt is never raised without its enable
   assert_irq_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_irq |-> ctl_rdata[27] && sts_rdata[30]);

endmodule

// File: tb/wdog_escalator_tb.sv
module wdog_escalator_tb;
   localparam int BASE = 3;
   localparam int STEP = 1;
   localparam int CW   = BASE + 3 * STEP + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        sts_we = 1'b0;
   logic [31:0] sts_wdata = '0;
   logic [31:0] ctl_rdata, sts_rdata;
   logic        wd_irq, rst_req;
   logic [1:0]  rst_kind;

   always #5 clk = ~clk;

   wdog_escalator #(.TB_BASE_BIT(BASE), .TB_STEP(STEP), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .sts_we(sts_we), .sts_wdata(sts_wdata),
      .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
      .wd_irq(wd_irq), .rst_req(rst_req), .rst_kind(rst_kind)
   );

   typedef struct {
      logic [31:0] sts;
      logic [31:0] ctl;
      logic        irq;
      logic        req;
      logic [1:0]  kind;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   // reference state
   logic [CW-1:0] m_cnt = '0;
   logic [5:0]    m_sts = '0;
   logic [8:0]    m_ctl = '0;
   bit            m_done = 0;

   function automatic bit next_tick_expires();
      int k;
      logic [CW-1:0] nc;
      k  = BASE + STEP * int'(m_ctl[8:7]);
      nc = m_cnt + 1'b1;
      return !m_cnt[k] && nc[k];
   endfunction

   task automatic cyc(input logic tk, input logic cw, input logic [31:0] cd,
                      input logic sw, input logic [31:0] sd, input string tag);
      logic [CW-1:0] nc;
      bit ex, hit, fire;
      logic [1:0] kind;
      exp_t e;
      @(negedge clk);
      tick_en = tk; ctl_we = cw; ctl_wdata = cd; sts_we = sw; sts_wdata = sd;
      ex = tk && next_tick_expires();
      @(posedge clk);
      #1;
      nc = tk ? m_cnt + 1'b1 : m_cnt;
      hit = 0; fire = 0; kind = 2'b00;
      if (sw) m_sts = sd[31:26];
      else if (ex && !m_done) begin
         case (m_sts[5:4])
            2'b00, 2'b01: m_sts[5] = 1'b1;
            2'b10:        m_sts[4] = 1'b1;
            default: begin
               m_sts[3:2] = m_ctl[6:5];
               hit = 1;
               fire = (m_ctl[6:5] != 2'b00);
               kind = fire ? m_ctl[6:5] : 2'b00;
            end
         endcase
      end
      m_done = (m_sts[5:4] == 2'b11) && (m_done || hit);
      if (cw) m_ctl = cd[31:23];
      m_cnt = nc;
      e.sts = {m_sts, 26'b0};
      e.ctl = {m_ctl, 23'b0};
      e.irq = m_sts[4] & m_ctl[4];
      e.req = fire;
      e.kind = kind;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, '0, tag);
   endtask

   // monitor: compare one expected item per cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (sts_rdata !== e.sts || ctl_rdata !== e.ctl || wd_irq !== e.irq ||
             rst_req !== e.req || rst_kind !== e.kind) begin
            n_bad++;
            $display("FAIL %s: sts=%h ctl=%h irq=%b req=%b kind=%b, expected sts=%h ctl=%h irq=%b req=%b kind=%b",
                     e.tag, sts_rdata, ctl_rdata, wd_irq, rst_req, rst_kind,
                     e.sts, e.ctl, e.irq, e.req, e.kind);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      idle(2, "R1");
      // R2: only control bits 31:23 kept
      cyc(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R2");
      // R3: only status bits 31:26 kept
      cyc(1'b0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, "R3");
      cyc(1'b0, 1'b0, '0, 1'b1, 32'h0000_0000, "R3");
      // period 0, reset kind 01, interrupt enabled
      cyc(1'b0, 1'b1, 32'h1800_0000, 1'b0, '0, "R2");
      // R4: no advance without tick
      idle(5, "R4");
      // R5: first expiry arms
      ticks(16, "R5");
      // R6: second expiry, interrupt raised
      ticks(16, "R6");
      // R7: final stage, pulse with kind 01
      ticks(16, "R7");
      // R8: further expiries ignored
      ticks(40, "R8");
      // R9: software service restarts
      cyc(1'b0, 1'b0, '0, 1'b1, 32'h0000_0000, "R9");
      ticks(16, "R9");
      // R6: interrupt disabled, reset kind 00, period 2
      cyc(1'b0, 1'b1, 32'h8000_0000, 1'b0, '0, "R6");
      ticks(140, "R6");
      // R7: final stage with kind 00 issues nothing
      ticks(70, "R7");
      cyc(1'b0, 1'b0, '0, 1'b1, 32'h0000_0000, "R9");
      // R5: state 01 goes to 11; kind 11, period 1
      cyc(1'b0, 1'b1, 32'h7800_0000, 1'b1, 32'h4000_0000, "R5");
      ticks(40, "R5");
      ticks(40, "R7");
      // R3: status write wins over an expiry at the same edge
      cyc(1'b0, 1'b1, 32'h2800_0000, 1'b1, 32'h0000_0000, "R3");
      while (!next_tick_expires()) ticks(1, "R4");
      cyc(1'b1, 1'b0, '0, 1'b1, 32'h0400_0000, "R3");
      ticks(20, "R3");
      // period 3 with kind 10
      cyc(1'b0, 1'b1, 32'hE800_0000, 1'b1, 32'h0000_0000, "R4");
      ticks(400, "R4");
      idle(3, "R8");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule